// File: doc/BRIEF.md
# I/O Address Translation Unit

This block turns the addresses that devices use for DMA into physical memory addresses. The mapping table lives in system memory. The block keeps two 64-bit registers. The control register holds an enable bit, a table page-size select and a 3-bit table-size code. The base register holds the byte address of the table. Software reaches each register as two 32-bit halves through a small register port.

A translation request arrives on a valid/ready handshake. If translation is off, the address passes straight through. If it is on, the block works out where the entry sits in the table, issues one 64-bit read on a simple request/response memory port, and reorders the returned bytes as a big-endian word. It then decodes the entry into a translated address, an offset mask, a write-permission flag and a fault flag. Only one request is in flight at a time.

Top module: `io_xlate_unit`

## Requirements
- R1: After synchronous reset both registers read as zero, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The 4-bit register offset selects a half. 0x0 is control bits 63:32 and 0x4 is control bits 31:0. 0x8 is base bits 63:32 and 0xC is base bits 31:0. `reg_rdata` shows the selected half combinationally. Any offset whose two low bits are not zero ignores writes and reads as zero.
- R3: With control bit 0 clear, the response comes in the cycle after acceptance. It carries `rsp_paddr` equal to the request address, `rsp_mask` = 0x1FFF, `rsp_wr_ok` = 1 and `rsp_fault` = 0, and no memory read is issued.
- R4: With translation on and control bit 2 clear, let c be control bits 18:16. The entry address is base + 8 × address bits [22+c:13].
- R5: With translation on, control bit 2 set and c ≤ 5, the entry address is base + 8 × address bits [25+c:16].
- R6: With control bit 2 set and c equal to 6 or 7, no memory read is issued. The response comes in the cycle after acceptance with fault = 1 and paddr, mask and wr_ok all zero.
- R7: `mem_rsp_data` bits [8k+7:8k] carry the byte at entry address + k. The block treats the byte at the lowest address as the most significant byte of the entry.
- R8: An entry with bit 63 clear gives fault = 1 and paddr, mask and wr_ok all zero.
- R9: For a valid entry, `rsp_wr_ok` equals entry bit 1.
- R10: A valid entry with bit 61 set gives mask 0xFFFF and paddr = {entry[40:16], addr[15:0]}. With bit 61 clear it gives mask 0x1FFF and paddr = {entry[40:13], addr[12:0]}. All paddr bits above 40 are zero.
- R11: `req_ready` is low from acceptance through the cycle in which `rsp_valid` is high. A table walk raises `mem_req_valid` for exactly the one cycle after acceptance. `rsp_valid` is high for the single cycle after `mem_rsp_valid` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register half write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register half |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | Device address to translate |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_paddr | output | 64 | Translated physical address |
| rsp_mask | output | 64 | Page offset mask |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_fault | output | 1 | Translation fault |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_addr | output | 64 | Table entry byte address |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry bytes in memory order |

## Verification
The bench targets the extreme table-size codes in both table modes, codes 6 and 7 in 64 KB mode, and entries that are invalid, read-only or large-page.

Getting each of these wrong shows up in a specific way:
- An off-by-one index width, or the wrong shift between the two modes, puts the wrong value on `mem_req_addr`.
- Treating the unsupported codes as legal issues a memory read where none is allowed.
- A missing byte reversal scrambles every translated address.
- Merging the page base with the wrong mask corrupts bits 13 to 15 of the result.

Unaligned register offsets, and writes to one half that must leave the other half unchanged, catch a loose offset decode.

// File: rtl/iox_pkg.sv
`timescale 1ns/1ps
package iox_pkg;
    localparam int XW      = 64;
    localparam int HW      = 32;
    localparam int NREG    = 2;
    localparam int OFS_8K  = 13;
    localparam int OFS_64K = 16;
    localparam int IDX_MIN = 10;
    localparam logic [2:0] MAX_BIG_CODE = 3'd5;
    localparam logic [XW-1:0] MASK_8K  = 64'h1FFF;
    localparam logic [XW-1:0] MASK_64K = 64'hFFFF;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT, ST_DONE} iox_state_t;

    typedef struct packed {
        logic [XW-1:0] paddr;
        logic [XW-1:0] mask;
        logic          wr_ok;
        logic          fault;
    } iox_result_t;

    function automatic logic [XW-1:0] byte_reverse(input logic [XW-1:0] d);
        logic [XW-1:0] r;
        for (int k = 0; k < XW/8; k++) begin
            r[8*k +: 8] = d[XW-8-8*k +: 8];
        end
        return r;
    endfunction

    function automatic iox_result_t pass_result(input logic [XW-1:0] a);
        iox_result_t r;
        r.paddr = a;
        r.mask  = MASK_8K;
        r.wr_ok = 1'b1;
        r.fault = 1'b0;
        return r;
    endfunction

    function automatic iox_result_t fault_result();
        iox_result_t r;
        r.paddr = '0;
        r.mask  = '0;
        r.wr_ok = 1'b0;
        r.fault = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/iox_regs.sv
`timescale 1ns/1ps
module iox_regs
    import iox_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [3:0]    addr,
    input  logic [HW-1:0] wdata,
    output logic [HW-1:0] rdata,
    output logic [XW-1:0] ctl,
    output logic [XW-1:0] base
);
    logic aligned;
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [XW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && aligned && (addr[3] == 1'(g))) begin
                if (!addr[2]) q[XW-1:HW] <= wdata;
                else          q[HW-1:0]  <= wdata;
            end
        end
    end

    assign ctl  = g_reg[0].q;
    assign base = g_reg[1].q;

    always_comb begin
        logic [XW-1:0] sel;
        sel   = addr[3] ? base : ctl;
        rdata = '0;
        if (aligned) rdata = addr[2] ? sel[HW-1:0] : sel[XW-1:HW];
    end

    assert_ctl_lo_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 4'h4) |=> ctl[HW-1:0] == $past(wdata));
    assert_base_hi_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 4'h8) |=> base[XW-1:HW] == $past(wdata));
endmodule

// File: rtl/iox_index.sv
`timescale 1ns/1ps
module iox_index
    import iox_pkg::*;
(
    input  logic [XW-1:0] addr,
    input  logic [XW-1:0] base,
    input  logic          big_tbl,
    input  logic [2:0]    size_code,
    output logic [XW-1:0] entry_addr,
    output logic          size_fault
);
    always_comb begin
        logic [5:0]    width;
        logic [5:0]    shift;
        logic [XW-1:0] field;
        size_fault = big_tbl && (size_code > MAX_BIG_CODE);
        width      = 6'(IDX_MIN) + {3'b000, size_code};
        shift      = big_tbl ? 6'(OFS_64K) : 6'(OFS_8K);
        field      = (addr >> shift) & ((64'd1 << width) - 64'd1);
        entry_addr = base + (field << 3);
    end
endmodule

// File: rtl/iox_decode.sv
`timescale 1ns/1ps
module iox_decode
    import iox_pkg::*;
(
    input  logic [XW-1:0] raw,
    input  logic [XW-1:0] addr,
    output iox_result_t   res
);
    logic [XW-1:0] entry;
    logic          unused_entry_bits;

    assign entry = byte_reverse(raw);
    assign unused_entry_bits = ^{entry[62], entry[60:41], entry[12:2], entry[0]};

    always_comb begin
        if (!entry[63]) begin
            res = fault_result();
        end else begin
            res.fault = 1'b0;
            res.wr_ok = entry[1];
            if (entry[61]) begin
                res.mask  = MASK_64K;
                res.paddr = {23'b0, entry[40:16], 16'b0} | (addr & MASK_64K);
            end else begin
                res.mask  = MASK_8K;
                res.paddr = {23'b0, entry[40:13], 13'b0} | (addr & MASK_8K);
            end
        end
    end
endmodule

// File: rtl/io_xlate_unit.sv
`timescale 1ns/1ps
module io_xlate_unit
    import iox_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr_en,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [63:0]   req_addr,
    output logic          rsp_valid,
    output logic [63:0]   rsp_paddr,
    output logic [63:0]   rsp_mask,
    output logic          rsp_wr_ok,
    output logic          rsp_fault,
    output logic          mem_req_valid,
    output logic [63:0]   mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [63:0]   mem_rsp_data
);
    logic [XW-1:0] ctl, base, ent_addr, ent_addr_q, addr_q;
    logic          size_fault, xl_en, accept, unused_ctl_bits;
    iox_state_t    state;
    iox_result_t   dec_res, res_q;

    iox_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctl(ctl), .base(base)
    );

    iox_index u_index (
        .addr(req_addr), .base(base), .big_tbl(ctl[2]), .size_code(ctl[18:16]),
        .entry_addr(ent_addr), .size_fault(size_fault)
    );

    iox_decode u_decode (.raw(mem_rsp_data), .addr(addr_q), .res(dec_res));

    assign xl_en           = ctl[0];
    assign unused_ctl_bits = ^{ctl[63:19], ctl[15:3], ctl[1]};
    assign req_ready       = (state == ST_IDLE);
    assign accept          = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            res_q      <= '0;
            addr_q     <= '0;
            ent_addr_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    addr_q <= req_addr;
                    if (!xl_en) begin
                        res_q <= pass_result(req_addr);
                        state <= ST_DONE;
                    end else if (size_fault) begin
                        res_q <= fault_result();
                        state <= ST_DONE;
                    end else begin
                        ent_addr_q <= ent_addr;
                        state      <= ST_FETCH;
                    end
                end
                ST_FETCH: state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    res_q <= dec_res;
                    state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid     = (state == ST_DONE);
    assign rsp_paddr     = res_q.paddr;
    assign rsp_mask      = res_q.mask;
    assign rsp_wr_ok     = res_q.wr_ok;
    assign rsp_fault     = res_q.fault;
    assign mem_req_valid = (state == ST_FETCH);
    assign mem_req_addr  = ent_addr_q;

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);
    assert_single_mem_req_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);
    assert_rsp_after_mem_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && mem_rsp_valid) |=> rsp_valid);
    assert_passthrough_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && !xl_en) |=> (rsp_valid && !mem_req_valid && rsp_wr_ok
                                && rsp_paddr == $past(req_addr)));
    assert_fault_clean_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (!rsp_wr_ok && rsp_paddr == '0 && rsp_mask == '0));
    assert_size_fault_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && xl_en && size_fault) |=> (rsp_valid && rsp_fault));
endmodule

// File: tb/io_xlate_unit_test.sv
`timescale 1ns/1ps
module io_xlate_unit_test;
    logic clk = 0, rst = 1;
    logic reg_wr_en = 0; logic [3:0] reg_addr = 0; logic [31:0] reg_wdata = 0, reg_rdata;
    logic req_valid = 0, req_ready; logic [63:0] req_addr = 0;
    logic rsp_valid, rsp_wr_ok, rsp_fault; logic [63:0] rsp_paddr, rsp_mask;
    logic mem_req_valid; logic [63:0] mem_req_addr;
    logic mem_rsp_valid = 0; logic [63:0] mem_rsp_data = 0;

    int total = 0, bad = 0, cycles = 0;
    bit mon_on = 0, exp_ready = 1, exp_rsp = 0, exp_mreq = 0;
    logic [63:0] m_ctl = 0, m_base = 0;

    io_xlate_unit uut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison of handshake outputs against the behavioural model
    always @(posedge clk) begin
        cycles++;
        #2;
        if (mon_on) begin
            chk("R11 req_ready", {63'b0, req_ready}, {63'b0, exp_ready});
            chk("R11 rsp_valid", {63'b0, rsp_valid}, {63'b0, exp_rsp});
            chk("R11 mem_req_valid", {63'b0, mem_req_valid}, {63'b0, exp_mreq});
        end
    end

    initial begin
        while (cycles < 100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=%0d exp=<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        if (a[1:0] == 0) begin
            if (!a[3]) begin if (!a[2]) m_ctl[63:32] = d; else m_ctl[31:0] = d; end
            else       begin if (!a[2]) m_base[63:32] = d; else m_base[31:0] = d; end
        end
        @(negedge clk); reg_wr_en = 0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] e);
        reg_addr = a; #1;
        chk(req, {32'b0, reg_rdata}, {32'b0, e});
    endtask

    function automatic logic [63:0] swap(input logic [63:0] e);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = e[63-8*k -: 8];
        return r;
    endfunction

    // reference translation computed from the requirements
    task automatic xlate(input string req, input logic [63:0] a, input logic [63:0] entry);
        bit fetch = 1, flt = 0, wrk = 0;
        logic [63:0] eaddr = 0, pa = 0, mk = 0, idx, phys;
        int code = int'(m_ctl[18:16]);
        bit big = m_ctl[2];
        if (!m_ctl[0]) begin
            fetch = 0; pa = a; mk = 64'h1FFF; wrk = 1;
        end else if (big && code >= 6) begin
            fetch = 0; flt = 1;
        end else begin
            idx = (a >> (big ? 16 : 13)) % (64'd1 << (10 + code));
            eaddr = m_base + idx * 8;
            if (!entry[63]) flt = 1;
            else begin
                wrk = entry[1];
                mk = entry[61] ? 64'hFFFF : 64'h1FFF;
                phys = entry & (entry[61] ? 64'h1FF_FFFF_8000 : 64'h1FF_FFFF_E000);
                pa = (phys & ~mk) | (a & mk);
            end
        end
        req_valid = 1; req_addr = a;
        @(posedge clk);
        exp_ready = 0;
        if (fetch) exp_mreq = 1; else exp_rsp = 1;
        @(negedge clk); req_valid = 0; req_addr = 0;
        if (fetch) begin
            chk({req, " R4/R5 entry addr"}, mem_req_addr, eaddr);
            @(posedge clk); exp_mreq = 0;
            @(negedge clk); mem_rsp_valid = 1; mem_rsp_data = swap(entry);
            @(posedge clk); exp_rsp = 1;
            @(negedge clk); mem_rsp_valid = 0; mem_rsp_data = 0;
        end
        chk({req, " paddr R7"}, rsp_paddr, pa);
        chk({req, " mask"}, rsp_mask, mk);
        chk({req, " wr_ok R9"}, {63'b0, rsp_wr_ok}, {63'b0, wrk});
        chk({req, " fault"}, {63'b0, rsp_fault}, {63'b0, flt});
        @(posedge clk); exp_rsp = 0; exp_ready = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        chk("R1 ready", {63'b0, req_ready}, 64'd1);
        chk("R1 rsp_valid", {63'b0, rsp_valid}, 64'd0);
        chk("R1 mem_req", {63'b0, mem_req_valid}, 64'd0);
        for (int i = 0; i < 4; i++) rd_chk("R1 reg zero", 4'(i * 4), 32'h0);
        mon_on = 1;
        @(negedge clk);

        // R2 register halves and unaligned offsets
        wr(4'h8, 32'h0000_0001); wr(4'hC, 32'h2000_0000);
        rd_chk("R2 base hi", 4'h8, 32'h0000_0001);
        rd_chk("R2 base lo", 4'hC, 32'h2000_0000);
        wr(4'h0, 32'hDEAD_BEEF);
        rd_chk("R2 ctl hi", 4'h0, 32'hDEAD_BEEF);
        rd_chk("R2 ctl lo untouched", 4'h4, 32'h0);
        wr(4'h6, 32'hFFFF_FFFF); wr(4'hD, 32'hFFFF_FFFF);
        rd_chk("R2 unaligned read", 4'h6, 32'h0);
        rd_chk("R2 unaligned write ignored ctl", 4'h4, 32'h0);
        rd_chk("R2 unaligned write ignored base", 4'hC, 32'h2000_0000);
        wr(4'h0, 32'h0);

        // R3 pass-through
        xlate("R3 pass", 64'h1234_5678_9ABC_DEF0, 64'h0);
        xlate("R3 pass2", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);

        // R4 8 KB table, codes 0, 3, 7; R10 small page, R9 write bit
        wr(4'h4, 32'h0000_0001);
        xlate("R4 c0 R10 8K rw", 64'h0000_0000_FFFF_F123, 64'h8000_0123_4567_A003);
        wr(4'h4, 32'h0003_0001);
        xlate("R4 c3 R9 ro", 64'h0000_0000_0ABC_D5A5, 64'h8000_0000_0002_2000);
        wr(4'h4, 32'h0007_0001);
        xlate("R4 c7 R8 invalid", 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF);
        xlate("R4 c7 R10 64K page", 64'h0000_0000_3FFF_ABCD, 64'hA000_01FF_FFFF_8002);

        // R5 64 KB table, codes 0 and 5; R6 codes 6 and 7
        wr(4'h4, 32'h0000_0005);
        xlate("R5 c0 R10", 64'h0000_0000_03FF_E7E7, 64'hA000_00AB_CDEF_0002);
        wr(4'h4, 32'h0005_0005);
        xlate("R5 c5 R10 8K", 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0155_5555_4000);
        wr(4'h4, 32'h0006_0005);
        xlate("R6 c6 fault", 64'h0000_0000_1234_5678, 64'h0);
        wr(4'h4, 32'h0007_0005);
        xlate("R6 c7 fault", 64'h0000_0000_7FFF_0000, 64'h0);

        // translation disabled again while 64K mode bits remain
        wr(4'h4, 32'h0007_0004);
        xlate("R3 pass big", 64'h0000_0000_0000_2222, 64'h0);

        mon_on = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule